// File: doc/BRIEF.md
# SDRAM Auto-Refresh Scheduler

This block decides when a synchronous DRAM controller must spend a command slot on an AUTO REFRESH, so that every row is refreshed within each retention period. It does not drive the memory pins and does not arbitrate. It raises a request toward the command arbiter and waits for an acknowledge. Because the device generates its own refresh row address, the request carries no address. Each acknowledged request stands for exactly one refresh command. No refresh state is held from one command to the next.

Two policies are available through `burst_mode`. In distributed mode, one refresh becomes owed at a fixed interval. That interval is the retention period in clocks divided by the number of refreshes the device needs per period. In burst mode, the full quota for the period is released at the start of each period. The spacing rule then issues those refreshes back to back, one row-cycle time apart. A small saturating ledger counts refreshes that are owed but not yet acknowledged. It raises `urgent` when it is full, so the arbiter can give refresh precedence over other traffic.

The refresh count per period (`REF_COUNT`, default 4096) is a property of the device, not of the controller. `PERIOD_CYCLES` gives the retention period in clocks. `TRC_CYCLES` gives the minimum spacing between refresh commands. `OWED_MAX` gives the ledger depth. `burst_mode` is meant to be held steady and changed only across a reset.

Top module: `rf_sched`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, `ref_req` is 0, `owed_cnt` is 0 and `urgent` is 0.
- R2: In distributed mode (`burst_mode`=0), the owed count rises by one every INTERVAL = PERIOD_CYCLES/REF_COUNT clock edges. The first rise is on the INTERVAL-th edge after reset is released.
- R3: `ref_req` is high exactly when the owed count is non-zero and the spacing window (R6) has expired. Once high, it stays high until an acknowledge is taken.
- R4: An acknowledge is taken only on an edge where both `ref_ack` and `ref_req` are high, and each taken acknowledge lowers the owed count by one. When `ref_req` is low, `ref_ack` is ignored and leaves the owed count unchanged.
- R5: The owed count saturates at OWED_MAX. A credit that arrives while the count is full, with no acknowledge taken on the same edge, is dropped. `urgent` is high exactly when the owed count equals OWED_MAX.
- R6: After a taken acknowledge, `ref_req` stays low for TRC_CYCLES-1 cycles, so two taken acknowledges are at least TRC_CYCLES edges apart (TRC_CYCLES >= 2).
- R7: In burst mode (`burst_mode`=1), on the first edge of each period (the first edge after reset, then every PERIOD_CYCLES edges), the quota is reloaded to REF_COUNT. Whenever the quota is non-zero and the ledger is not full, one credit is added per edge. With an always-ready arbiter, exactly REF_COUNT acknowledges are taken in each period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| burst_mode | input | 1 | 0: distributed policy, 1: burst policy |
| ref_ack | input | 1 | Arbiter accepts the pending refresh |
| ref_req | output | 1 | A refresh command is wanted now |
| owed_cnt | output | $clog2(OWED_MAX+1) | Refreshes owed and not yet acknowledged |
| urgent | output | 1 | Ledger is full |

## Verification
Distributed mode is first run with an arbiter that never acknowledges. This shows the credit interval, the first request edge and the saturation point, where one dropped credit separates a correct ledger from an overflowing one. Switching the same run to an always-ready arbiter drains the ledger. That drain shows the row-cycle spacing between taken acknowledges, and shows that an acknowledge offered while the request is low has no effect. Burst mode with an always-ready arbiter, over two periods, separates a correct per-period quota reload from a quota that is lost or duplicated. A cycle-level reference model built from the requirements scores the request, count and urgent outputs on every cycle of every phase.

// File: rtl/rf_pkg.sv
package rf_pkg;

    typedef enum logic {
        RF_DISTRIB = 1'b0,
        RF_BURST   = 1'b1
    } rf_mode_e;

    // Saturating ledger step: one increment and one decrement may meet.
    function automatic int unsigned owed_step(
        input int unsigned cur,
        input logic        inc,
        input logic        dec,
        input int unsigned cap
    );
        int unsigned nxt;
        nxt = cur;
        if (inc && !dec) begin
            nxt = (cur >= cap) ? cap : cur + 1;
        end else if (dec && !inc && cur != 0) begin
            nxt = cur - 1;
        end
        return nxt;
    endfunction

endpackage

// File: rtl/rf_period_timer.sv
module rf_period_timer #(
    parameter int PERIOD_CYCLES = 6400000,
    parameter int INTERVAL      = 1562
) (
    input  logic clk,
    input  logic rst,
    output logic period_start,
    output logic ivl_tick
);
    localparam int PW = (PERIOD_CYCLES > 1) ? $clog2(PERIOD_CYCLES) : 1;
    localparam int IW = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;

    logic [PW-1:0] pcnt_q;
    logic [IW-1:0] icnt_q;

    assign period_start = (pcnt_q == '0);
    assign ivl_tick     = (icnt_q == IW'(INTERVAL - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            pcnt_q <= '0;
            icnt_q <= '0;
        end else begin
            pcnt_q <= (pcnt_q == PW'(PERIOD_CYCLES - 1)) ? '0 : pcnt_q + 1'b1;
            icnt_q <= ivl_tick ? '0 : icnt_q + 1'b1;
        end
    end

    // Interval ticks are isolated single pulses (INTERVAL >= 2).
    assert_tick_single_R2: assert property (@(posedge clk) disable iff (rst)
        ivl_tick |=> !ivl_tick);

endmodule

// File: rtl/rf_credit_src.sv
module rf_credit_src
    import rf_pkg::*;
#(
    parameter int REF_COUNT = 4096
) (
    input  logic     clk,
    input  logic     rst,
    input  rf_mode_e mode,
    input  logic     period_start,
    input  logic     ivl_tick,
    input  logic     owed_full,
    output logic     credit
);
    localparam int BW = $clog2(REF_COUNT + 1);

    logic [BW-1:0] quota_q;
    logic          burst_credit;

    assign burst_credit = (quota_q != '0) && !owed_full;

    generate
        if (REF_COUNT > 0) begin : g_mux
            always_comb begin
                case (mode)
                    RF_BURST: credit = burst_credit;
                    default:  credit = ivl_tick;
                endcase
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst || mode != RF_BURST) begin
            quota_q <= '0;
        end else if (period_start) begin
            quota_q <= BW'(REF_COUNT);
        end else if (burst_credit) begin
            quota_q <= quota_q - 1'b1;
        end
    end

    // Each period start in burst mode yields a full quota on the next cycle.
    assert_quota_reload_R7: assert property (@(posedge clk) disable iff (rst)
        (mode == RF_BURST && period_start) |=> quota_q == BW'(REF_COUNT));

endmodule

// File: rtl/rf_owed_ledger.sv
module rf_owed_ledger
    import rf_pkg::*;
#(
    parameter int OWED_MAX   = 8,
    parameter int TRC_CYCLES = 7,
    parameter int OW         = $clog2(OWED_MAX + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          credit,
    input  logic          ref_ack,
    output logic          ref_req,
    output logic [OW-1:0] owed_cnt,
    output logic          urgent
);
    localparam int GW = (TRC_CYCLES > 1) ? $clog2(TRC_CYCLES) : 1;

    logic [OW-1:0] owed_q;
    logic [GW-1:0] gap_q;
    logic          accept;

    assign ref_req  = (owed_q != '0) && (gap_q == '0);
    assign accept   = ref_req && ref_ack;
    assign owed_cnt = owed_q;
    assign urgent   = (owed_q == OW'(OWED_MAX));

    always_ff @(posedge clk) begin
        if (rst) begin
            owed_q <= '0;
            gap_q  <= '0;
        end else begin
            owed_q <= OW'(owed_step(int'(owed_q), credit, accept, OWED_MAX));
            if (accept) begin
                gap_q <= GW'(TRC_CYCLES - 1);
            end else if (gap_q != '0) begin
                gap_q <= gap_q - 1'b1;
            end
        end
    end

    assert_req_held_R3: assert property (@(posedge clk) disable iff (rst)
        (ref_req && !ref_ack) |=> ref_req);

    assert_ack_drains_R4: assert property (@(posedge clk) disable iff (rst)
        (accept && !credit) |=> owed_q == $past(owed_q) - 1'b1);

    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (rst)
        (urgent && !accept) |=> urgent);

    assert_spacing_R6: assert property (@(posedge clk) disable iff (rst)
        accept |=> !ref_req);

endmodule

// File: rtl/rf_sched.sv
module rf_sched
    import rf_pkg::*;
#(
    parameter int REF_COUNT     = 4096,
    parameter int PERIOD_CYCLES = 6400000,
    parameter int TRC_CYCLES    = 7,
    parameter int OWED_MAX      = 8,
    parameter int OW            = $clog2(OWED_MAX + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          burst_mode,
    input  logic          ref_ack,
    output logic          ref_req,
    output logic [OW-1:0] owed_cnt,
    output logic          urgent
);
    localparam int INTERVAL = PERIOD_CYCLES / REF_COUNT;

    rf_mode_e mode;
    logic     period_start;
    logic     ivl_tick;
    logic     credit;

    assign mode = burst_mode ? RF_BURST : RF_DISTRIB;

    rf_period_timer #(
        .PERIOD_CYCLES(PERIOD_CYCLES),
        .INTERVAL     (INTERVAL)
    ) u_timer (
        .clk         (clk),
        .rst         (rst),
        .period_start(period_start),
        .ivl_tick    (ivl_tick)
    );

    rf_credit_src #(
        .REF_COUNT(REF_COUNT)
    ) u_credit (
        .clk         (clk),
        .rst         (rst),
        .mode        (mode),
        .period_start(period_start),
        .ivl_tick    (ivl_tick),
        .owed_full   (urgent),
        .credit      (credit)
    );

    rf_owed_ledger #(
        .OWED_MAX  (OWED_MAX),
        .TRC_CYCLES(TRC_CYCLES),
        .OW        (OW)
    ) u_ledger (
        .clk     (clk),
        .rst     (rst),
        .credit  (credit),
        .ref_ack (ref_ack),
        .ref_req (ref_req),
        .owed_cnt(owed_cnt),
        .urgent  (urgent)
    );

endmodule

// File: tb/rf_sched_tb.sv
module rf_sched_tb;
    localparam int CLK_PERIOD = 10;
    localparam int REFS = 4;
    localparam int PER  = 200;
    localparam int TRC  = 5;
    localparam int OMAX = 8;
    localparam int IVL  = PER / REFS;
    localparam int OW   = $clog2(OMAX + 1);

    typedef struct {
        logic req;
        int   owed;
        logic urg;
    } exp_t;

    logic          clk = 0;
    logic          rst = 1;
    logic          burst_mode = 0;
    logic          ref_ack = 0;
    logic          ref_req;
    logic [OW-1:0] owed_cnt;
    logic          urgent;

    int total = 0;
    int bad = 0;
    int ecnt = 0;
    int last_acc = -1000;
    int acc_per[2];
    exp_t sb[$];

    // reference model state
    int m_t = 0, m_iv = 0, m_owed = 0, m_gap = 0, m_bl = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rf_sched #(
        .REF_COUNT(REFS), .PERIOD_CYCLES(PER), .TRC_CYCLES(TRC), .OWED_MAX(OMAX)
    ) u_dut (
        .clk(clk), .rst(rst), .burst_mode(burst_mode), .ref_ack(ref_ack),
        .ref_req(ref_req), .owed_cnt(owed_cnt), .urgent(urgent)
    );

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at edge %0d", tag, act, exp, ecnt);
        end
    endtask

    // driver side: reference model pushes expected outputs after each edge
    always @(posedge clk) begin
        exp_t e;
        logic m_req, cr, acc;
        if (rst) begin
            m_t = 0; m_iv = 0; m_owed = 0; m_gap = 0; m_bl = 0;
            ecnt = 0;
        end else begin
            ecnt++;
            m_req = (m_owed != 0) && (m_gap == 0);
            acc   = m_req && ref_ack;
            if (burst_mode) cr = (m_bl != 0) && (m_owed < OMAX);
            else            cr = (m_iv == IVL - 1);
            if (cr && !acc)      m_owed = (m_owed >= OMAX) ? OMAX : m_owed + 1;
            else if (acc && !cr) m_owed = m_owed - 1;
            if (!burst_mode)     m_bl = 0;
            else if (m_t == 0)   m_bl = REFS;
            else if (cr)         m_bl = m_bl - 1;
            if (acc)             m_gap = TRC - 1;
            else if (m_gap > 0)  m_gap = m_gap - 1;
            m_t  = (m_t == PER - 1) ? 0 : m_t + 1;
            m_iv = (m_iv == IVL - 1) ? 0 : m_iv + 1;
        end
        e.req  = (m_owed != 0) && (m_gap == 0);
        e.owed = m_owed;
        e.urg  = (m_owed == OMAX);
        sb.push_back(e);
    end

    // monitor: pop and compare away from the edge; track taken acks
    always @(negedge clk) begin
        exp_t e;
        if (sb.size() != 0) begin
            e = sb.pop_front();
            check("R3 req", int'(ref_req), int'(e.req));
            check("R4 owed", int'(owed_cnt), e.owed);
            check("R5 urgent", int'(urgent), int'(e.urg));
        end
        if (!rst && ref_req && ref_ack) begin
            check("R6 spacing>=TRC", (ecnt + 1 - last_acc >= TRC) ? 1 : 0, 1);
            last_acc = ecnt + 1;
            if (burst_mode && ecnt < 2 * PER) acc_per[ecnt / PER]++;
        end
    end

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
    endtask

    initial begin
        acc_per[0] = 0; acc_per[1] = 0;
        // distributed, arbiter never ready
        edges(3);
        @(negedge clk);
        check("R1 req in reset", int'(ref_req), 0);
        check("R1 owed in reset", int'(owed_cnt), 0);
        check("R1 urgent in reset", int'(urgent), 0);
        @(posedge clk); #1 rst = 0;
        edges(IVL - 1); @(negedge clk);
        check("R2 no credit before interval", int'(owed_cnt), 0);
        edges(1); @(negedge clk);
        check("R2 first credit", int'(owed_cnt), 1);
        check("R3 req raised", int'(ref_req), 1);
        edges(IVL * (OMAX - 1) - 1); @(negedge clk);
        check("R5 not yet full", int'(urgent), 0);
        edges(1); @(negedge clk);
        check("R5 full count", int'(owed_cnt), OMAX);
        check("R5 urgent", int'(urgent), 1);
        edges(IVL + 5); @(negedge clk);
        check("R5 credit dropped", int'(owed_cnt), OMAX);
        // arbiter always ready: drain, then acks offered while req low
        @(posedge clk); #1 ref_ack = 1;
        edges(TRC * OMAX + 20); @(negedge clk);
        check("R4 drained", int'(owed_cnt) <= 1 ? 1 : 0, 1);
        edges(IVL * 3);
        // burst mode, arbiter always ready, two periods
        @(posedge clk); #1 rst = 1; burst_mode = 1; last_acc = -1000;
        edges(2);
        @(posedge clk); #1 rst = 0;
        edges(2 * PER + 5); @(negedge clk);
        check("R7 quota period 0", acc_per[0], REFS);
        check("R7 quota period 1", acc_per[1], REFS);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        total++; bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule